// File: doc/BRIEF.md
# Memory Block Copy and Search Sequencer

This sequencer carries out byte-wide block transfers and block searches on behalf of an 8-bit processor core. A single start command loads a source pointer, a destination pointer, a byte count and a key byte, and selects the operation (copy or search), the pointer direction (up or down) and whether the operation runs once or repeats. The sequencer then issues byte read and write requests on a single-outstanding request/acknowledge memory port and advances the pointers and the count after each byte.

A copy moves the byte at the source pointer to the destination pointer. A search compares the key with the byte at the source pointer and records the outcome in flags, never writing memory and never changing the key. A repeating copy runs until the count is used up. A repeating search also stops early on the first byte equal to the key. Two flags are kept: a match flag and a count-remaining flag. A busy level and a one-cycle done pulse let the core stall until the sequence has ended.

Top module: `blkmove_engine`

## Requirements
- R1: After reset busy, done and mem_req are low, both flags are clear and the source pointer, destination pointer and count outputs are zero.
- R2: A copy step reads the byte at the source pointer, writes it to the destination pointer, moves both pointers by one and lowers the count by one.
- R3: With cmd_dec=1 the pointers move down by one per step, with cmd_dec=0 they move up by one; the count is lowered by one in both directions.
- R4: A repeating copy (cmd_repeat=1) keeps stepping until the count reaches zero; a single copy (cmd_repeat=0) performs exactly one step.
- R5: A search step (cmd_search=1) reads the byte at the source pointer, moves only the source pointer by one and lowers the count by one; it issues no write and leaves the destination pointer unchanged.
- R6: A repeating search ends after the first step whose byte equals the key, or after the step that brings the count to zero, whichever comes first.
- R7: flag_match is 1 when the byte compared in the last search step equals the key and 0 otherwise; a copy leaves it unchanged.
- R8: After every step of either kind, flag_cnt_nz is 1 exactly when the count is non-zero.
- R9: A start with a count of zero still performs a step; the count wraps to all ones, so a repeating copy covers 2^ADDR_W bytes.
- R10: busy is high from the cycle after a start until the last acknowledge; done pulses high for one cycle, in the cycle after the last acknowledge, with busy already low.
- R11: At most one request is outstanding; once mem_req is raised, it and mem_addr, mem_we and mem_wdata hold until mem_ack is seen.
- R12: A start asserted while busy is high is ignored: the running operation's results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command, sampled while idle |
| cmd_search | input | 1 | 1 selects search, 0 selects copy |
| cmd_dec | input | 1 | 1 moves pointers down, 0 moves them up |
| cmd_repeat | input | 1 | 1 repeats until termination, 0 does one step |
| init_src | input | ADDR_W | Source pointer loaded on start |
| init_dst | input | ADDR_W | Destination pointer loaded on start |
| init_cnt | input | ADDR_W | Byte count loaded on start |
| init_key | input | DATA_W | Key byte loaded on start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_match | output | 1 | Last compared byte equalled the key |
| flag_cnt_nz | output | 1 | Count non-zero after the last step |
| src_ptr | output | ADDR_W | Current source pointer |
| dst_ptr | output | ADDR_W | Current destination pointer |
| byte_cnt | output | ADDR_W | Current byte count |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request accepted and completed this cycle |

## Verification
A corrupted count shows up as a run of the wrong length: extra or missing bytes in the destination region and a wrong byte_cnt at done, visible as soon as the sequence ends, while a wrongly stepped pointer puts a wrong address on mem_addr at the very next request. A stale match or count flag is visible at flag_match or flag_cnt_nz in the cycle after the step's acknowledge. A sequencing fault appears as done without busy falling, a second done pulse, a write during a search, or a request whose address changes before its acknowledge. Sweeping every mode combination over a small address width, including the wrapping zero count, exposes each of these within one operation.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic search;
    logic dec;
    logic rep;
  } op_cfg_t;
endpackage

// File: rtl/blkmove_ptrs.sv
module blkmove_ptrs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              dec,
  input  logic              step_src,
  input  logic              step_dst,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic [ADDR_W-1:0] ld_cnt,
  input  logic [DATA_W-1:0] ld_key,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] cnt_q,
  output logic [DATA_W-1:0] key_q,
  output logic              cnt_last
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] src_d, dst_d, cnt_d;
  logic [DATA_W-1:0] key_d;
  logic              src_en, dst_en, cnt_en, key_en;

  always_comb begin
    src_en = load | step_src;
    dst_en = load | step_dst;
    cnt_en = load | step_src;
    key_en = load;
    if (load) begin
      src_d = ld_src;
      dst_d = ld_dst;
      cnt_d = ld_cnt;
    end else begin
      src_d = dec ? (src_q - ONE) : (src_q + ONE);
      dst_d = dec ? (dst_q - ONE) : (dst_q + ONE);
      cnt_d = cnt_q - ONE;
    end
    key_d = ld_key;
  end

  assign cnt_last = (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      key_q <= '0;
    end else begin
      if (src_en) src_q <= src_d;
      if (dst_en) dst_q <= dst_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (key_en) key_q <= key_d;
    end
  end

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_src && !load) |=> (cnt_q == $past(cnt_q) - ONE));

  assert_src_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_src && !load) |=> ((src_q == $past(src_q) + ONE) || (src_q == $past(src_q) - ONE)));

  assert_dst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_dst && !load) |=> $stable(dst_q));
endmodule

// File: rtl/blkmove_flags.sv
module blkmove_flags #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] key,
  input  logic [ADDR_W-1:0] cnt,
  output logic              hit,
  output logic              match_q,
  output logic              nz_q
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic match_d, nz_d;

  always_comb begin
    hit     = (rdata == key);
    match_d = hit;
    nz_d    = (cnt != ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      nz_q    <= 1'b0;
    end else begin
      if (cmp_en) match_q <= match_d;
      if (upd_en) nz_q    <= nz_d;
    end
  end

  assert_nz_tracks_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (nz_q == (cnt != '0)));

  assert_match_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(match_q));
endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
  import blkmove_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_cfg_t           cfg_in,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              cnt_last,
  input  logic              hit,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              load,
  output logic              dec,
  output logic              step_src,
  output logic              step_dst,
  output logic              cmp_en,
  output logic              upd_en,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  seq_state_t        st_q, st_d;
  op_cfg_t           cfg_q, cfg_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              done_q, done_d;
  logic              byte_en, cfg_en;

  always_comb begin
    st_d     = st_q;
    cfg_d    = cfg_in;
    cfg_en   = 1'b0;
    byte_d   = mem_rdata;
    byte_en  = 1'b0;
    done_d   = 1'b0;
    load     = 1'b0;
    step_src = 1'b0;
    step_dst = 1'b0;
    cmp_en   = 1'b0;
    upd_en   = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = src;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          load   = 1'b1;
          cfg_en = 1'b1;
          st_d   = ST_READ;
        end
      end
      ST_READ: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (cfg_q.search) begin
            step_src = 1'b1;
            cmp_en   = 1'b1;
            upd_en   = 1'b1;
            if (!cfg_q.rep || cnt_last || hit) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end else begin
            byte_en = 1'b1;
            st_d    = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst;
        if (mem_ack) begin
          step_src = 1'b1;
          step_dst = 1'b1;
          upd_en   = 1'b1;
          if (!cfg_q.rep || cnt_last) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d = ST_READ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      byte_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (cfg_en)  cfg_q  <= cfg_d;
      if (byte_en) byte_q <= byte_d;
    end
  end

  assign dec       = cfg_q.dec;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign mem_wdata = byte_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_search_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_q.search) |-> !(mem_req && mem_we));
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_search,
  input  logic              cmd_dec,
  input  logic              cmd_repeat,
  input  logic [ADDR_W-1:0] init_src,
  input  logic [ADDR_W-1:0] init_dst,
  input  logic [ADDR_W-1:0] init_cnt,
  input  logic [DATA_W-1:0] init_key,
  output logic              busy,
  output logic              done,
  output logic              flag_match,
  output logic              flag_cnt_nz,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic [ADDR_W-1:0] byte_cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  op_cfg_t           cfg_in;
  logic              load, dec, step_src, step_dst, cmp_en, upd_en;
  logic              cnt_last, hit;
  logic [DATA_W-1:0] key_q;

  assign cfg_in = '{search: cmd_search, dec: cmd_dec, rep: cmd_repeat};

  blkmove_ptrs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .load(load), .dec(dec),
    .step_src(step_src), .step_dst(step_dst),
    .ld_src(init_src), .ld_dst(init_dst), .ld_cnt(init_cnt), .ld_key(init_key),
    .src_q(src_ptr), .dst_q(dst_ptr), .cnt_q(byte_cnt), .key_q(key_q),
    .cnt_last(cnt_last)
  );

  blkmove_flags #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .upd_en(upd_en),
    .rdata(mem_rdata), .key(key_q), .cnt(byte_cnt),
    .hit(hit), .match_q(flag_match), .nz_q(flag_cnt_nz)
  );

  blkmove_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
    .src(src_ptr), .dst(dst_ptr), .cnt_last(cnt_last), .hit(hit),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .load(load), .dec(dec), .step_src(step_src), .step_dst(step_dst),
    .cmp_en(cmp_en), .upd_en(upd_en), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/sim_blkmove_engine.sv
`timescale 1ns/1ps
module sim_blkmove_engine;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cmd_search = 1'b0, cmd_dec = 1'b0, cmd_repeat = 1'b0;
  logic [AW-1:0] init_src = '0, init_dst = '0, init_cnt = '0;
  logic [DW-1:0] init_key = '0;
  logic busy, done, flag_match, flag_cnt_nz, mem_req, mem_we;
  logic [AW-1:0] src_ptr, dst_ptr, byte_cnt, mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #2 clk = ~clk;

  blkmove_engine #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_search(cmd_search),
    .cmd_dec(cmd_dec), .cmd_repeat(cmd_repeat), .init_src(init_src),
    .init_dst(init_dst), .init_cnt(init_cnt), .init_key(init_key),
    .busy(busy), .done(done), .flag_match(flag_match), .flag_cnt_nz(flag_cnt_nz),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .byte_cnt(byte_cnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [DW-1:0] mem [MSZ];
  logic [DW-1:0] exp_mem [MSZ];
  int total = 0, bad = 0;
  int wsel = 0, wcnt = 0;
  int ndone = 0, done_busy = 0, hold_viol = 0, cyc = 0;
  logic prev_pend = 1'b0, prev_we = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic exp_match = 1'b0, exp_nz = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder and protocol monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we)) hold_viol++;
      if (done) begin
        ndone++;
        if (busy) done_busy++;
      end
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= wsel) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr];
          if (mem_we) mem[mem_addr] = mem_wdata;
        end else begin
          wcnt++;
        end
      end
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
      prev_we = mem_we;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=180000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_op(input logic srch, input logic dn, input logic rep,
                        input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                        input logic [AW-1:0] c0, input int kofs, input int seed,
                        input logic ignore_test);
    logic [AW-1:0] s, d, c;
    logic [DW-1:0] key;
    logic stop, eq;
    string tc, tm;
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = DW'(i * 7 + 3 + seed);
      exp_mem[i] = mem[i];
    end
    key = mem[dn ? AW'(s0 - AW'(kofs)) : AW'(s0 + AW'(kofs))];
    // reference model
    s = s0; d = d0; c = c0;
    do begin
      if (srch) begin
        eq = (exp_mem[s] == key);
        exp_match = eq;
        s = dn ? s - 1'b1 : s + 1'b1;
        c = c - 1'b1;
        stop = !rep || (c == 0) || eq;
      end else begin
        exp_mem[d] = exp_mem[s];
        s = dn ? s - 1'b1 : s + 1'b1;
        d = dn ? d - 1'b1 : d + 1'b1;
        c = c - 1'b1;
        stop = !rep || (c == 0);
      end
      exp_nz = (c != 0);
    end while (!stop);
    @(negedge clk);
    ndone = 0; done_busy = 0; hold_viol = 0;
    cmd_search = srch; cmd_dec = dn; cmd_repeat = rep;
    init_src = s0; init_dst = d0; init_cnt = c0; init_key = key;
    start = 1'b1;
    @(negedge clk);
    chk("R10 busy after start", int'(busy), 1);
    if (ignore_test) begin
      cmd_search = ~srch; cmd_dec = ~dn; cmd_repeat = 1'b1;
      init_src = s0 + 8'h33; init_dst = d0 + 8'h11; init_cnt = 8'h7; init_key = ~key;
    end else begin
      start = 1'b0;
    end
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 5000 && !done; g++) @(negedge clk);
    chk("R10 done seen with busy low", int'(done && !busy), 1);
    repeat (4) @(negedge clk);
    chk("R10 one done pulse", ndone, 1);
    chk("R10 busy low at done", done_busy, 0);
    chk("R11 request held until ack", hold_viol, 0);
    if (c0 == 0 && rep && !srch) tc = "R9 wrapped count";
    else if (rep) tc = srch ? "R6 count" : "R4 count";
    else tc = srch ? "R5 count" : "R2 count";
    chk(tc, int'(byte_cnt), int'(c));
    chk(ignore_test ? "R12 src after ignored start" : "R3 src pointer", int'(src_ptr), int'(s));
    chk(srch ? "R5 dst unchanged" : "R3 dst pointer", int'(dst_ptr), int'(srch ? d0 : d));
    chk("R7 match flag", int'(flag_match), int'(exp_match));
    chk("R8 count flag", int'(flag_cnt_nz), int'(exp_nz));
    tm = srch ? "R5 memory untouched" : (rep ? "R4 memory copy" : "R2 memory copy");
    begin
      int nbad = 0;
      for (int i = 0; i < MSZ; i++) if (mem[i] !== exp_mem[i]) nbad++;
      chk(tm, nbad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 flags", int'({flag_match, flag_cnt_nz}), 0);
    chk("R1 pointers", int'(src_ptr) + int'(dst_ptr) + int'(byte_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    begin
      int n = 0;
      for (int m = 0; m < 8; m++) begin
        for (int k = 0; k < 4; k++) begin
          logic [AW-1:0] cv;
          cv = (k == 0) ? 8'd1 : (k == 1) ? 8'd2 : (k == 2) ? 8'd5 : 8'd0;
          wsel = n % 3;
          run_op(m[2], m[1], m[0], 8'h40, 8'hA0, cv,
                 (cv == 8'd2) ? 10 : 3, n, 1'b0);
          n++;
        end
      end
      // overlapping regions in both directions
      wsel = 1;
      run_op(1'b0, 1'b0, 1'b1, 8'h10, 8'h12, 8'd9, 3, 50, 1'b0);
      run_op(1'b0, 1'b1, 1'b1, 8'h20, 8'h1E, 8'd9, 3, 51, 1'b0);
      // start pulses during busy must be ignored
      wsel = 2;
      run_op(1'b0, 1'b0, 1'b1, 8'h80, 8'hC0, 8'd6, 3, 52, 1'b1);
      run_op(1'b1, 1'b1, 1'b1, 8'hF0, 8'h00, 8'd0, 3, 53, 1'b1);
      // search wrapping over the full range without early match
      wsel = 0;
      run_op(1'b1, 1'b0, 1'b1, 8'h05, 8'h00, 8'd0, 255, 54, 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule